// File: doc/BRIEF.md
# Trap Context Register File

This block keeps the processor state that describes the most recent trap and the privilege and interrupt-enable mode around it. It has four 32-bit registers, each read by a register number over a combinational read port: a mode register, a cause register, a return-address register and a faulting-address register. A software write port updates the fields that software may change.

When the trap strobe is high, the block stores the return address, which is the address of the offending instruction. It records the trap code and pushes a three-level mode stack, so the core runs in kernel mode with interrupts disabled. For address-error traps it also captures the faulting data address. A return strobe pops the mode stack. Hardware interrupt lines set sticky pending flags. The block raises an interrupt request when the current enable bit and an unmasked pending flag are both set. A constant output gives the handler entry address for loading into the program counter.

Top module: `trap_ctx_regs`

## Requirements
- R1: Register numbers are 8 = faulting address, 12 = mode, 13 = cause and 14 = return address. Any other number reads 0, and field bits not defined below read 0.
- R2: The mode register holds the interrupt mask in bits 15:8, where a 1 enables that level. Bits 5:0 hold three (k, e) pairs, with current in 1:0, previous in 3:2 and oldest in 5:4; k is the upper bit of each pair. A software write to number 12 loads both fields. A software write to number 14 loads the return address.
- R3: On a trap, mode bits 5:0 become the old bits 3:0 shifted up by two, and bits 1:0 become 00 (kernel mode, interrupts disabled).
- R4: On a return without a trap, mode bits 3:0 take the old bits 5:2 and bits 5:4 keep their value.
- R5: In the same cycle, a trap has priority over a return and over a software write to the mode register or the return-address register. A return has priority over a software write to the mode register.
- R6: On a trap the return-address register receives the trap PC input minus 4. The trap PC input is the address of the instruction after the offending one.
- R7: Cause bits 15:10 are pending flags for hardware lines 0 to 5. A line that is high at a clock edge sets its flag. The flag stays set, even while interrupts are disabled, until a software write to number 13 has a 0 in that bit. A line arriving in the same cycle as such a write keeps the flag set.
- R8: `irq_req_o` is 1 exactly when mode bit 0 is 1 and some pending flag has its mask bit set; flag i pairs with mask bit 10+i.
- R9: On a trap, cause bits 5:2 take the trap code and software cannot write them. The faulting-address register captures the fault address only for codes 4 and 5, and software cannot write it.
- R10: `handler_pc_o` is always 0x80000080.
- R11: After reset all four registers read 0 and `irq_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Trap entry strobe |
| trap_code_i | input | 4 | Trap code recorded on entry |
| trap_pc_i | input | 32 | Address of the instruction after the offending one |
| fault_addr_i | input | 32 | Data address of the faulting reference |
| rfe_i | input | 1 | Return-from-trap strobe |
| hw_irq_i | input | 6 | Hardware interrupt lines |
| wr_en_i | input | 1 | Software write enable |
| wr_sel_i | input | 5 | Register number for the write |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 5 | Register number for the read |
| rd_data_o | output | 32 | Read data |
| handler_pc_o | output | 32 | Handler entry address |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
The hardest cases to reach are same-cycle collisions. One is a trap that lands together with a return and a mode-register write. Another is a clearing write to the cause register that meets a newly arriving hardware line. A third is a pending flag that is raised while interrupts are disabled and must still be there once they are enabled. Directed cycles set up each collision with known mode-stack contents, so every priority outcome produces a different read value. A long random phase then mixes traps, returns, writes and interrupt pulses. A behavioural model checks every cycle.

// File: rtl/trap_ctx_pkg.sv
package trap_ctx_pkg;
  localparam int XLEN      = 32;
  localparam int SEL_W     = 5;
  localparam int N_HW      = 6;
  localparam int MASK_W    = 8;
  localparam int CODE_W    = 4;
  localparam int STACK_W   = 6;
  localparam int INSN_BYTES = 4;

  localparam logic [SEL_W-1:0] SEL_FAULT = 5'd8;
  localparam logic [SEL_W-1:0] SEL_MODE  = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE = 5'd13;
  localparam logic [SEL_W-1:0] SEL_RET   = 5'd14;

  localparam logic [XLEN-1:0]   HANDLER_PC    = 32'h8000_0080;
  localparam logic [CODE_W-1:0] CODE_ADDR_LD  = 4'd4;
  localparam logic [CODE_W-1:0] CODE_ADDR_ST  = 4'd5;
endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/trap_mode_stack.sv
module trap_mode_stack
  import trap_ctx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_i,
  input  logic               rfe_i,
  input  logic               wr_i,
  input  logic [MASK_W-1:0]  wr_mask_i,
  input  logic [STACK_W-1:0] wr_stack_i,
  output logic [MASK_W-1:0]  mask_o,
  output logic [STACK_W-1:0] stack_o
);
  logic [MASK_W-1:0]  mask_q, mask_d;
  logic [STACK_W-1:0] stack_q, stack_d;
  logic               upd_en;

  always_comb begin
    mask_d  = mask_q;
    stack_d = stack_q;
    upd_en  = 1'b0;
    if (trap_i) begin
      stack_d = {stack_q[STACK_W-3:0], 2'b00};
      upd_en  = 1'b1;
    end else if (rfe_i) begin
      stack_d = {stack_q[STACK_W-1:STACK_W-2], stack_q[STACK_W-1:2]};
      upd_en  = 1'b1;
    end else if (wr_i) begin
      mask_d  = wr_mask_i;
      stack_d = wr_stack_i;
      upd_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      stack_q <= '0;
    end else if (upd_en) begin
      mask_q  <= mask_d;
      stack_q <= stack_d;
    end
  end

  assign mask_o  = mask_q;
  assign stack_o = stack_q;
endmodule

// File: rtl/trap_cause_reg.sv
module trap_cause_reg
  import trap_ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [N_HW-1:0]   hw_irq_i,
  input  logic              wr_i,
  input  logic [N_HW-1:0]   wr_keep_i,
  output logic [N_HW-1:0]   pend_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N_HW-1:0]   pend_q, pend_d;
  logic [CODE_W-1:0] code_q;
  logic              pend_en;

  always_comb begin
    pend_d  = (wr_i ? (pend_q & wr_keep_i) : pend_q) | hw_irq_i;
    pend_en = wr_i | (|hw_irq_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (trap_i) code_q <= code_i;
  end

  assign pend_o = pend_q;
  assign code_o = code_q;
endmodule

// File: rtl/trap_addr_capture.sv
module trap_addr_capture
  import trap_ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   next_pc_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic              wr_ret_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output logic [XLEN-1:0]   ret_o,
  output logic [XLEN-1:0]   fault_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] ret_q, ret_d, fault_q;
  logic            ret_en, fault_en;

  always_comb begin
    ret_en   = trap_i | wr_ret_i;
    ret_d    = trap_i ? (next_pc_i - STEP) : wr_data_i;
    fault_en = trap_i & ((code_i == CODE_ADDR_LD) | (code_i == CODE_ADDR_ST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ret_q <= '0;
    else if (ret_en) ret_q <= ret_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_q <= '0;
    else if (fault_en) fault_q <= fault_addr_i;
  end

  assign ret_o   = ret_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/trap_ctx_regs.sv
module trap_ctx_regs
  import trap_ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic [XLEN-1:0]   trap_pc_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic              rfe_i,
  input  logic [N_HW-1:0]   hw_irq_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [XLEN-1:0]   rd_data_o,
  output logic [XLEN-1:0]   handler_pc_o,
  output logic              irq_req_o
);
  localparam int PEND_LO = 16 - N_HW;

  logic                srst_n;
  logic [MASK_W-1:0]   mask;
  logic [STACK_W-1:0]  stack;
  logic [N_HW-1:0]     pend;
  logic [CODE_W-1:0]   code;
  logic [XLEN-1:0]     ret_addr, fault_addr;
  logic                wr_mode, wr_cause, wr_ret;

  assign wr_mode  = wr_en_i & (wr_sel_i == SEL_MODE);
  assign wr_cause = wr_en_i & (wr_sel_i == SEL_CAUSE);
  assign wr_ret   = wr_en_i & (wr_sel_i == SEL_RET);

  trap_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  trap_mode_stack u_mode (
    .clk(clk), .rst_n(srst_n), .trap_i(trap_i), .rfe_i(rfe_i), .wr_i(wr_mode),
    .wr_mask_i(wr_data_i[15:8]), .wr_stack_i(wr_data_i[STACK_W-1:0]),
    .mask_o(mask), .stack_o(stack)
  );

  trap_cause_reg u_cause (
    .clk(clk), .rst_n(srst_n), .trap_i(trap_i), .code_i(trap_code_i),
    .hw_irq_i(hw_irq_i), .wr_i(wr_cause), .wr_keep_i(wr_data_i[15:PEND_LO]),
    .pend_o(pend), .code_o(code)
  );

  trap_addr_capture u_addr (
    .clk(clk), .rst_n(srst_n), .trap_i(trap_i), .code_i(trap_code_i),
    .next_pc_i(trap_pc_i), .fault_addr_i(fault_addr_i), .wr_ret_i(wr_ret),
    .wr_data_i(wr_data_i), .ret_o(ret_addr), .fault_o(fault_addr)
  );

  always_comb begin
    case (rd_sel_i)
      SEL_FAULT: rd_data_o = fault_addr;
      SEL_MODE:  rd_data_o = {16'h0, mask, 2'b00, stack};
      SEL_CAUSE: rd_data_o = {16'h0, pend, {(PEND_LO-2-CODE_W){1'b0}}, code, 2'b00};
      SEL_RET:   rd_data_o = ret_addr;
      default:   rd_data_o = '0;
    endcase
  end

  assign irq_req_o    = stack[0] & (|(pend & mask[MASK_W-1:MASK_W-N_HW]));
  assign handler_pc_o = HANDLER_PC;
endmodule

// File: rtl/trap_ctx_regs_chk.sv
module trap_ctx_regs_chk
  import trap_ctx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               trap_i,
  input logic               rfe_i,
  input logic [XLEN-1:0]    trap_pc_i,
  input logic               wr_en_i,
  input logic [SEL_W-1:0]   wr_sel_i,
  input logic [STACK_W-1:0] stack,
  input logic [N_HW-1:0]    pend,
  input logic [XLEN-1:0]    ret_addr,
  input logic               irq_req_o
);
  a_r3_entry_push: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> stack == {$past(stack[3:0]), 2'b00});

  a_r4_return_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !trap_i) |=> stack == {$past(stack[5:4]), $past(stack[5:2])});

  a_r5_trap_over_write: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && wr_en_i && wr_sel_i == SEL_MODE) |=> stack[1:0] == 2'b00);

  a_r6_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> ret_addr == $past(trap_pc_i) - 32'd4);

  a_r7_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i == SEL_CAUSE) |=> (pend & $past(pend)) == $past(pend));

  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !stack[0] |-> !irq_req_o);
endmodule

bind trap_ctx_regs trap_ctx_regs_chk u_chk (
  .clk(clk), .rst_n(srst_n), .trap_i(trap_i), .rfe_i(rfe_i), .trap_pc_i(trap_pc_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .stack(stack), .pend(pend),
  .ret_addr(ret_addr), .irq_req_o(irq_req_o)
);

// File: tb/trap_ctx_regs_bench.sv
`timescale 1ns/100ps
module trap_ctx_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_i, rfe_i, wr_en_i;
  logic [3:0]  trap_code_i;
  logic [31:0] trap_pc_i, fault_addr_i, wr_data_i;
  logic [5:0]  hw_irq_i;
  logic [4:0]  wr_sel_i, rd_sel_i;
  logic [31:0] rd_data_o, handler_pc_o;
  logic        irq_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_ctx_regs u_trap_ctx_regs (.*);

  // Behavioural reference model
  logic [7:0]  m_mask;
  logic [5:0]  m_stk, m_pend;
  logic [3:0]  m_code;
  logic [31:0] m_ret, m_fault;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_stk = 0; m_pend = 0; m_code = 0; m_ret = 0; m_fault = 0;
    end else begin
      if (wr_en_i && wr_sel_i == 13) m_pend = m_pend & wr_data_i[15:10];
      m_pend = m_pend | hw_irq_i;
      if (trap_i) begin
        m_stk  = {m_stk[3:0], 2'b00};
        m_code = trap_code_i;
        m_ret  = trap_pc_i - 4;
        if (trap_code_i == 4 || trap_code_i == 5) m_fault = fault_addr_i;
      end else begin
        if (rfe_i) m_stk = {m_stk[5:4], m_stk[5:2]};
        else if (wr_en_i && wr_sel_i == 12) begin
          m_mask = wr_data_i[15:8];
          m_stk  = wr_data_i[5:0];
        end
        if (wr_en_i && wr_sel_i == 14) m_ret = wr_data_i;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] s);
    case (s)
      5'd8:    return m_fault;
      5'd12:   return {16'h0, m_mask, 2'b00, m_stk};
      5'd13:   return {16'h0, m_pend, 4'h0, m_code, 2'b00};
      5'd14:   return m_ret;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] s);
    case (s)
      5'd8:    return "R9";
      5'd12:   return "R3";
      5'd13:   return "R7";
      5'd14:   return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk(tag_of(rd_sel_i), rd_data_o, m_read(rd_sel_i));
      chk("R8", {31'h0, irq_req_o},
          {31'h0, m_stk[0] & (|(m_pend & m_mask[7:2]))});
      chk("R10", handler_pc_o, 32'h8000_0080);
    end
  end

  task automatic idle();
    trap_i = 0; rfe_i = 0; wr_en_i = 0; hw_irq_i = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic peek(input string tag, input logic [4:0] s, input logic [31:0] exp);
    rd_sel_i = s; #0.1;
    chk(tag, rd_data_o, exp);
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    wr_en_i = 1; wr_sel_i = s; wr_data_i = d;
  endtask

  task automatic trap(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] fa);
    trap_i = 1; trap_code_i = c; trap_pc_i = pc; fault_addr_i = fa;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(); trap_code_i = 0; trap_pc_i = 0; fault_addr_i = 0;
    wr_sel_i = 0; wr_data_i = 0; rd_sel_i = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) step();

    // R11 reset state
    peek("R11", 8, 0); peek("R11", 12, 0); peek("R11", 13, 0); peek("R11", 14, 0);
    chk("R11", {31'h0, irq_req_o}, 0);
    chk("R10", handler_pc_o, 32'h8000_0080);

    // R2 mask write, interrupts disabled
    wr(12, 32'h0000_FC00); step();
    peek("R2", 12, 32'h0000_FC00);

    // R7 pending set while disabled
    hw_irq_i = 6'b000001; step(); step();
    peek("R7", 13, 32'h0000_0400);
    chk("R8", {31'h0, irq_req_o}, 0);

    // R8 enable -> request
    wr(12, 32'h0000_FC05); step();
    chk("R8", {31'h0, irq_req_o}, 1);

    // R3/R6 trap entry, code 0
    trap(4'd0, 32'h0000_1004, 32'h0); step();
    peek("R6", 14, 32'h0000_1000);
    peek("R3", 12, 32'h0000_FC14);
    peek("R9", 13, 32'h0000_0400);
    chk("R8", {31'h0, irq_req_o}, 0);

    // R4 return pop
    rfe_i = 1; step();
    peek("R4", 12, 32'h0000_FC15);
    chk("R8", {31'h0, irq_req_o}, 1);

    // R7 clearing write meets new arrival; R9 code not writable
    wr(13, 32'h0000_003C); hw_irq_i = 6'b000010; step();
    peek("R7", 13, 32'h0000_0800);

    // R8 masked off
    wr(12, 32'h0000_0315); step();
    chk("R8", {31'h0, irq_req_o}, 0);

    // R9 address error captures fault address
    trap(4'd4, 32'h0000_2000, 32'hDEAD_BEE0); step();
    peek("R9", 8, 32'hDEAD_BEE0);
    peek("R6", 14, 32'h0000_1FFC);
    peek("R9", 13, 32'h0000_0810);
    peek("R3", 12, 32'h0000_0314);

    // R9 syscall code leaves fault address
    trap(4'd8, 32'h0000_2100, 32'h0000_1234); step();
    peek("R9", 8, 32'hDEAD_BEE0);
    peek("R9", 13, 32'h0000_0820);
    peek("R3", 12, 32'h0000_0310);

    // R5 trap beats return and mode write
    trap(4'd12, 32'h0000_3008, 32'h0); rfe_i = 1; wr(12, 32'h0000_00FF); step();
    peek("R5", 12, 32'h0000_0300);
    peek("R5", 13, 32'h0000_0830);
    peek("R5", 14, 32'h0000_3004);

    // R5 return beats mode write
    wr(12, 32'h0000_0324); step();
    rfe_i = 1; wr(12, 32'h0000_FFFF); step();
    peek("R5", 12, 32'h0000_0329);

    // R2 return-address write; R5 trap beats it
    wr(14, 32'hABCD_0000); step();
    peek("R2", 14, 32'hABCD_0000);
    trap(4'd9, 32'h0000_0040, 32'h0); wr(14, 32'h0000_5555); step();
    peek("R5", 14, 32'h0000_003C);

    // R9 fault register not writable; R1 unmapped numbers
    wr(8, 32'h0); step();
    peek("R9", 8, 32'hDEAD_BEE0);
    peek("R1", 0, 0); peek("R1", 7, 0); peek("R1", 31, 0); peek("R1", 15, 0);

    // Random mix, checked every cycle against the model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r < 2) trap(4'($urandom_range(0, 12)), {$urandom, 2'b00} >> 2 << 2, $urandom);
      else if (r < 4) rfe_i = 1;
      if ($urandom_range(0, 3) == 0) begin
        int k;
        k = $urandom_range(0, 4);
        wr(k == 0 ? 5'd8 : k == 1 ? 5'd12 : k == 2 ? 5'd13 : k == 3 ? 5'd14 : 5'd3, $urandom);
      end
      if ($urandom_range(0, 4) == 0) hw_irq_i = 6'($urandom);
      begin
        int k;
        k = $urandom_range(0, 4);
        rd_sel_i = (k == 0) ? 5'd8 : (k == 1) ? 5'd12 : (k == 2) ? 5'd13 : (k == 3) ? 5'd14 : 5'd21;
      end
      step();
    end

    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule